// File: doc/BRIEF.md
# Pulse-Swallow Main Feedback Divider

This block is the feedback divider of a frequency synthesizer loop. It runs on the oscillator-rate clock and emits one pulse every N input cycles, where N = 64·B + A. Internally a dual-modulus prescaler, modelled as a counter whose length is either 64 or 65, is steered by two counters. A swallow counter holds the prescaler at length 65 for the first A prescaler cycles of each output period. A program counter ends the period after B prescaler cycles in total.

Both ratio fields are taken from a 24-bit configuration word. The divider samples that word only at the boundary between two output periods, so an update never shortens or stretches the period in progress. A word that cannot be realised is not adopted. In that case the divider keeps its previous ratio and raises an error flag until a usable word is taken at a later boundary.

Top module: `pulse_swallow_div`

## Requirements
- R1: The interval between consecutive output pulses is exactly 64·B + A input clock cycles, for the ratio in force during that period.
- R2: In cfg_word (bit 0 least significant), B is read from bits 19..9 with its MSB at bit 19, A from bits 8..2, and the prescaler-mode bit from bit 20. Bits 23..21 and 1..0 do not affect the period or the error flag.
- R3: div_out is high for exactly one input clock cycle per period.
- R4: Each period consists of B prescaler cycles. The first A of them last 65 input cycles and the rest last 64, so A may range from 0 to 63 when B allows it.
- R5: A word with B < 3 is rejected at the boundary. cfg_err goes high, and the previous ratio stays in force.
- R6: A word with A ≥ B, or with A ≥ 64, is rejected in the same way as in R5.
- R7: A word whose prescaler-mode bit is 1 (the reserved mode) is rejected in the same way as in R5. Mode 0 selects 64/65.
- R8: A change of cfg_word inside a period has no effect on that period. It is adopted at the next period boundary, and cfg_err and the active ratio change only there.
- R9: While rst is high, div_out and cfg_err are 0. The first clock edge after reset starts a period with the word presented then, and it produces no pulse. The first pulse is due N cycles later.
- R10: A legal word taken at a boundary clears cfg_err at that boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate input clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_word | input | 24 | Configuration word carrying the B field, the A field and the mode bit |
| div_out | output | 1 | Divided output, one cycle high per period |
| cfg_err | output | 1 | High while the last sampled word was rejected |

## Verification
Every result of this block appears at a period boundary. The pulse is registered, so it is visible in the cycle after the edge that ends the period. cfg_err is updated on that same edge, so it is valid from the same cycle as the pulse. Because of this, every check waits for a pulse sampled on the falling edge and then counts falling edges up to the next pulse, which yields N exactly. The error flag is read in the pulse cycle that follows a word change. The reset check counts from the falling edge where reset is released, which puts the first pulse N+1 falling edges later.

// File: rtl/pulse_swallow_pkg.sv
package pulse_swallow_pkg;

    // prescaler base modulus; the high modulus is PRESC + 1
    parameter int PRESC    = 64;
    parameter int B_W      = 11;
    parameter int A_W      = 7;
    parameter int WORD_W   = 24;
    parameter int B_LSB    = 9;
    parameter int A_LSB    = 2;
    parameter int MODE_BIT = 20;
    parameter int B_MIN    = 3;

    localparam int PRE_W  = $clog2(PRESC + 1);
    localparam int N_MIN  = PRESC * B_MIN;
    localparam int N_MAX  = PRESC * ((1 << B_W) - 1) + PRESC - 1;
    localparam int GAP_W  = $clog2(N_MAX + 1) + 1;

    typedef enum logic {
        MOD_LOW  = 1'b0,
        MOD_HIGH = 1'b1
    } modsel_e;

    typedef struct packed {
        logic [B_W-1:0] b;
        logic [A_W-1:0] a;
    } ratio_t;

    function automatic ratio_t word_ratio(input logic [WORD_W-1:0] w);
        ratio_t r;
        r.b = w[B_LSB +: B_W];
        r.a = w[A_LSB +: A_W];
        return r;
    endfunction

    function automatic logic ratio_legal(input ratio_t r, input logic mode);
        logic b_ok;
        logic a_ok;
        b_ok = (r.b >= B_W'(B_MIN));
        a_ok = (B_W'(r.a) < r.b) && (int'(r.a) < PRESC);
        return (mode == 1'b0) && b_ok && a_ok;
    endfunction

endpackage

// File: rtl/psd_cfg_shadow.sv
module psd_cfg_shadow
    import pulse_swallow_pkg::*;
#(
    parameter int DEF_B = 3,
    parameter int DEF_A = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] cfg_word,
    input  logic              period_end,
    output ratio_t            next_ratio,
    output ratio_t            act_ratio,
    output logic              cfg_err
);

    localparam ratio_t DEF_R = '{b: B_W'(DEF_B), a: A_W'(DEF_A)};

    ratio_t cand;
    logic   cand_ok;
    ratio_t act_q;
    logic   err_q;

    always_comb begin
        cand       = word_ratio(cfg_word);
        cand_ok    = ratio_legal(cand, cfg_word[MODE_BIT]);
        next_ratio = cand_ok ? cand : act_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= DEF_R;
            err_q <= 1'b0;
        end else if (period_end) begin
            act_q <= next_ratio;
            err_q <= !cand_ok;
        end
    end

    assign act_ratio = act_q;
    assign cfg_err   = err_q;

endmodule

// File: rtl/psd_prescaler.sv
module psd_prescaler
    import pulse_swallow_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  modsel_e          mod,
    output logic             pre_tc,
    output logic [PRE_W-1:0] pre_cnt
);

    localparam logic [PRE_W-1:0] LOAD_HIGH = PRE_W'(PRESC);
    localparam logic [PRE_W-1:0] LOAD_LOW  = PRE_W'(PRESC - 1);

    logic [PRE_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= (mod == MOD_HIGH) ? LOAD_HIGH : LOAD_LOW;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign pre_tc  = (cnt_q == '0);
    assign pre_cnt = cnt_q;

endmodule

// File: rtl/psd_swallow_ctl.sv
module psd_swallow_ctl
    import pulse_swallow_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           pre_tc,
    input  ratio_t         next_ratio,
    output logic           period_end,
    output modsel_e        mod,
    output logic [A_W-1:0] a_rem,
    output logic [B_W-1:0] b_rem
);

    logic [A_W-1:0] a_q;
    logic [B_W-1:0] b_q;
    logic [A_W-1:0] src_a;
    logic [B_W-1:0] src_b;

    always_comb begin
        period_end = pre_tc && (b_q == '0);
        if (period_end) begin
            src_a = next_ratio.a;
            src_b = next_ratio.b;
        end else begin
            src_a = a_q;
            src_b = b_q;
        end
        mod = (src_a != '0) ? MOD_HIGH : MOD_LOW;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q <= '0;
            b_q <= '0;
        end else if (pre_tc) begin
            a_q <= (mod == MOD_HIGH) ? src_a - 1'b1 : src_a;
            b_q <= src_b - 1'b1;
        end
    end

    assign a_rem = a_q;
    assign b_rem = b_q;

endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div
    import pulse_swallow_pkg::*;
#(
    parameter int DEF_B = 3,
    parameter int DEF_A = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] cfg_word,
    output logic              div_out,
    output logic              cfg_err
);

    ratio_t           next_ratio;
    ratio_t           act_ratio;
    logic             period_end;
    logic             pre_tc;
    logic [PRE_W-1:0] pre_cnt;
    modsel_e          mod;
    logic [A_W-1:0]   a_rem;
    logic [B_W-1:0]   b_rem;
    logic             primed_q;
    logic             div_q;

    psd_cfg_shadow #(
        .DEF_B(DEF_B),
        .DEF_A(DEF_A)
    ) u_shadow (
        .clk       (clk),
        .rst       (rst),
        .cfg_word  (cfg_word),
        .period_end(period_end),
        .next_ratio(next_ratio),
        .act_ratio (act_ratio),
        .cfg_err   (cfg_err)
    );

    psd_prescaler u_presc (
        .clk    (clk),
        .rst    (rst),
        .start  (pre_tc),
        .mod    (mod),
        .pre_tc (pre_tc),
        .pre_cnt(pre_cnt)
    );

    psd_swallow_ctl u_ctl (
        .clk       (clk),
        .rst       (rst),
        .pre_tc    (pre_tc),
        .next_ratio(next_ratio),
        .period_end(period_end),
        .mod       (mod),
        .a_rem     (a_rem),
        .b_rem     (b_rem)
    );

    // the boundary on the first edge after reset only starts counting
    always_ff @(posedge clk) begin
        if (rst) begin
            primed_q <= 1'b0;
            div_q    <= 1'b0;
        end else begin
            primed_q <= 1'b1;
            div_q    <= period_end && primed_q;
        end
    end

    assign div_out = div_q;

endmodule

// File: rtl/pulse_swallow_div_chk.sv
module pulse_swallow_div_chk
    import pulse_swallow_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             div_out,
    input logic             cfg_err,
    input logic             period_end,
    input logic [PRE_W-1:0] pre_cnt,
    input logic [A_W-1:0]   a_rem,
    input logic [B_W-1:0]   b_rem,
    input ratio_t           act_ratio
);

    logic [GAP_W-1:0] gap_q;
    logic             seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (div_out) begin
            gap_q  <= GAP_W'(1);
            seen_q <= 1'b1;
        end else if (gap_q != {GAP_W{1'b1}}) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    // R1
    period_range_chk: assert property (@(posedge clk) disable iff (rst)
        (div_out && seen_q) |-> (gap_q >= GAP_W'(N_MIN) && gap_q <= GAP_W'(N_MAX)));

    // R1
    pulse_at_end_chk: assert property (@(posedge clk) disable iff (rst)
        div_out |-> $past(period_end));

    // R3
    pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        div_out |=> !div_out);

    // R4
    swallow_order_chk: assert property (@(posedge clk) disable iff (rst)
        (a_rem != '0) |-> (B_W'(a_rem) < b_rem));

    // R4
    presc_range_chk: assert property (@(posedge clk) disable iff (rst)
        pre_cnt <= PRE_W'(PRESC));

    // R5
    active_legal_chk: assert property (@(posedge clk) disable iff (rst)
        ratio_legal(act_ratio, 1'b0));

    // R8
    ratio_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(act_ratio) |-> $past(period_end));

    // R10
    err_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(cfg_err) |-> $past(period_end));

endmodule

bind pulse_swallow_div pulse_swallow_div_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .div_out   (div_out),
    .cfg_err   (cfg_err),
    .period_end(period_end),
    .pre_cnt   (pre_cnt),
    .a_rem     (a_rem),
    .b_rem     (b_rem),
    .act_ratio (act_ratio)
);

// File: tb/pulse_swallow_div_bench.sv
module pulse_swallow_div_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [23:0] cfg_word = '0;
    logic        div_out;
    logic        cfg_err;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    pulse_swallow_div u_pulse_swallow_div (
        .clk     (clk),
        .rst     (rst),
        .cfg_word(cfg_word),
        .div_out (div_out),
        .cfg_err (cfg_err)
    );

    function automatic logic [23:0] mkw(input logic mode, input int b, input int a,
                                        input logic [2:0] spare, input logic [1:0] sel);
        return {spare, mode, 11'(b), 7'(a), sel};
    endfunction

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_pulse();
        do @(negedge clk); while (!div_out);
    endtask

    task automatic count_gap(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!div_out);
    endtask

    task automatic t_reset();
        int n;
        rst = 1'b1;
        cfg_word = mkw(1'b0, 3, 1, 3'b000, 2'b00);
        repeat (3) @(negedge clk);
        chk("R9 div_out in reset", div_out, 0);
        chk("R9 cfg_err in reset", cfg_err, 0);
        rst = 1'b0;
        count_gap(n);
        chk("R9 first pulse after reset", n, 194);
        chk("R9 cfg_err after reset", cfg_err, 0);
    endtask

    task automatic t_ratio(input int b, input int a, input string req);
        int n;
        cfg_word = mkw(1'b0, b, a, 3'b000, 2'b01);
        wait_pulse();
        chk({req, " cfg_err"}, cfg_err, 0);
        @(negedge clk);
        chk("R3 pulse width", div_out, 0);
        count_gap(n);
        chk({req, " period"}, n + 1, 64 * b + a);
    endtask

    task automatic t_spare_bits();
        int n;
        cfg_word = mkw(1'b0, 7, 5, 3'b111, 2'b10);
        wait_pulse();
        chk("R2 spare bits err", cfg_err, 0);
        count_gap(n);
        chk("R2 spare bits period", n, 453);
    endtask

    task automatic t_mid_update();
        int n;
        cfg_word = mkw(1'b0, 4, 3, 3'b000, 2'b01);
        wait_pulse();
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (n == 40) cfg_word = mkw(1'b0, 3, 2, 3'b000, 2'b01);
        end while (!div_out);
        chk("R8 period in progress kept", n, 259);
        count_gap(n);
        chk("R8 new ratio next period", n, 194);
    endtask

    task automatic t_illegal(input logic [23:0] w, input int keep_n, input string req);
        int n;
        cfg_word = w;
        wait_pulse();
        chk({req, " cfg_err raised"}, cfg_err, 1);
        count_gap(n);
        chk({req, " old ratio kept"}, n, keep_n);
        chk({req, " cfg_err held"}, cfg_err, 1);
    endtask

    task automatic t_recover();
        int n;
        cfg_word = mkw(1'b0, 6, 1, 3'b000, 2'b01);
        wait_pulse();
        chk("R10 cfg_err cleared", cfg_err, 0);
        count_gap(n);
        chk("R10 period after recovery", n, 385);
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_ratio(3, 0, "R1 minimum ratio");
        t_ratio(5, 4, "R4 A just below B");
        t_ratio(64, 63, "R4 A at P-1");
        t_spare_bits();
        t_mid_update();
        t_illegal(mkw(1'b0, 2, 0, 3'b000, 2'b01), 194, "R5 B below 3");
        t_illegal(mkw(1'b0, 5, 5, 3'b000, 2'b01), 194, "R6 A equal B");
        t_illegal(mkw(1'b0, 100, 64, 3'b000, 2'b01), 194, "R6 A at P");
        t_illegal(mkw(1'b1, 10, 0, 3'b000, 2'b01), 194, "R7 reserved mode");
        t_recover();
        t_ratio(99, 12, "R1 N 6348");
        t_ratio(260, 32, "R1 N 16672");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule